// File: doc/BRIEF.md
# Register Window Address Decoder

This block sits between a host bus and a 4 KiB register window. The host bus can issue byte, halfword and word accesses. The block looks at the low twelve offset bits of each access and sends the access to one of three places. The first is an embedded USB core's register port, which gets the offset unchanged. The second is the same core's endpoint FIFO port, reached through a folded address. The third is a small bank of local 32-bit registers.

Core accesses use a valid/ready handshake, and the core's read data goes straight back to the host in the cycle the core accepts the access. Local and unmapped accesses finish in the cycle they are presented. Unmapped reads return zero. Unmapped writes are dropped and raise a sticky error flag.

Top module: `regwin_decoder`

## Requirements
- R1: Only host address bits [11:0] take part in decoding; the upper address bits never change the target, the core address or the read data.
- R2: Offsets 0x400 to 0x5FF select the core register port: `core_reg_sel` is high and `core_addr` equals the offset's bits [8:0].
- R3: Offsets 0x600 to 0x7FF select the core FIFO port: `core_fifo_sel` is high and `core_addr` = 0x20 + ((offset >> 3) & 0x3C), so each 32-byte slot maps to one word-aligned FIFO address between 0x20 and 0x5C.
- R4: For a core target, `core_valid` follows `hst_valid` and `hst_ready` follows `core_ready`. The size code is forwarded on `core_size` (0 byte, 1 halfword, 2 word), and so are `hst_write` and `hst_wdata`. On a read, `hst_rdata` equals `core_rdata` in the same cycle.
- R5: Local registers (offset 0x800 and above) are decoded only for size code 2. A byte or halfword access there is treated as unmapped. Size code 3 is illegal anywhere and is treated as unmapped.
- R6: A read/write scratch register at offset 0x9C4 resets to 0. A word write to it is visible on the next read.
- R7: A read/write test-reset register at offset 0x9D8 resets to 0x0000A596.
- R8: The read-only registers return fixed values: 0x814 reads 0x00000120, 0x9F8 reads 0x5A5A0011, and 0x9FC reads 0x000000C3. Writes to them are ignored and do not raise the error flag.
- R9: A read of an unmapped offset returns zero.
- R10: A write to an unmapped offset changes no register and sets `decode_error`. The flag stays high until reset and is low after reset.
- R11: Local and unmapped accesses complete in the cycle they are presented (`hst_ready` high) and never assert `core_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_valid | input | 1 | Host access request |
| hst_ready | output | 1 | Access completes this cycle |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_addr | input | ADDR_W (16) | Host byte address |
| hst_size | input | 2 | 0 byte, 1 halfword, 2 word |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data |
| core_valid | output | 1 | Request to the USB core |
| core_ready | input | 1 | Core accepts the access |
| core_reg_sel | output | 1 | Request targets the core register port |
| core_fifo_sel | output | 1 | Request targets the core FIFO port |
| core_write | output | 1 | Write strobe toward the core |
| core_addr | output | 9 | Core-side address |
| core_size | output | 2 | Forwarded size code |
| core_wdata | output | 32 | Forwarded write data |
| core_rdata | input | 32 | Core read data, valid with core_ready |
| decode_error | output | 1 | Sticky unmapped-write flag |

## Verification
The assertions assume the host keeps `hst_valid`, the address, the size and the data stable until `hst_ready` is seen. They also assume `core_ready` is meaningful only while `core_valid` is high.

The stimulus keeps to these assumptions. Each access is driven just after a clock edge and held until a sampled handshake. `core_ready` is raised only after a chosen number of wait cycles, and the core read data is a pure function of the core address and size.

The bench covers every size code, including the illegal code 3. It also drives non-zero upper address bits and hits both edges of each sub-window, so the assertions on address folding and on the sticky flag see every class of access.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  localparam int OFF_W   = 12;
  localparam int CORE_AW = 9;

  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_BAD  = 2'd3;

  typedef enum logic [1:0] {
    TGT_NONE      = 2'd0,
    TGT_CORE_REG  = 2'd1,
    TGT_CORE_FIFO = 2'd2,
    TGT_LOCAL     = 2'd3
  } target_e;

  // Each 32-byte slot of the FIFO sub-window collapses onto one word address.
  function automatic logic [CORE_AW-1:0] fifo_fold(input logic [OFF_W-1:0] off);
    return 9'h020 + {3'b000, off[8:5], 2'b00};
  endfunction

  // Target selection from the window offset, the size code and the local hit.
  function automatic target_e classify(input logic [OFF_W-1:0] off,
                                       input logic [1:0] size,
                                       input logic local_hit);
    target_e t;
    t = TGT_NONE;
    if (size != SZ_BAD) begin
      if (off[11]) begin
        if (size == SZ_WORD && local_hit) t = TGT_LOCAL;
      end else if (off[10:9] == 2'b10) begin
        t = TGT_CORE_REG;
      end else if (off[10:9] == 2'b11) begin
        t = TGT_CORE_FIFO;
      end
    end
    return t;
  endfunction

endpackage

// File: rtl/regwin_sysbank.sv
module regwin_sysbank
  import regwin_pkg::*;
#(
  parameter int                        DATA_W      = 32,
  parameter logic [OFF_W-1:0]          SCRATCH_OFF = 12'h9C4,
  parameter logic [OFF_W-1:0]          TRESET_OFF  = 12'h9D8,
  parameter logic [DATA_W-1:0]         TRESET_INIT = 32'h0000_A596,
  parameter int                        NUM_RO      = 3,
  parameter logic [NUM_RO*OFF_W-1:0]   RO_OFFS     = {12'h9FC, 12'h9F8, 12'h814},
  parameter logic [NUM_RO*DATA_W-1:0]  RO_VALS     = {32'h0000_00C3, 32'h5A5A_0011, 32'h0000_0120}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFF_W-1:0]  off,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              hit,
  output logic [DATA_W-1:0] rdata
);

  logic              scr_hit, trs_hit;
  logic [DATA_W-1:0] scratch_q, treset_q;
  logic [NUM_RO-1:0] ro_hit;
  logic [DATA_W-1:0] ro_term [NUM_RO];
  logic [DATA_W-1:0] ro_data;

  assign scr_hit = (off == SCRATCH_OFF);
  assign trs_hit = (off == TRESET_OFF);

  for (genvar g = 0; g < NUM_RO; g++) begin : g_ro
    assign ro_hit[g]  = (off == RO_OFFS[g*OFF_W +: OFF_W]);
    assign ro_term[g] = ro_hit[g] ? RO_VALS[g*DATA_W +: DATA_W] : '0;
  end

  always_comb begin
    ro_data = '0;
    for (int i = 0; i < NUM_RO; i++) ro_data = ro_data | ro_term[i];
  end

  assign hit = scr_hit | trs_hit | (|ro_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
      treset_q  <= TRESET_INIT;
    end else if (wr_en) begin
      if (scr_hit) scratch_q <= wdata;
      if (trs_hit) treset_q  <= wdata;
    end
  end

  always_comb begin
    if (scr_hit)      rdata = scratch_q;
    else if (trs_hit) rdata = treset_q;
    else              rdata = ro_data;
  end

endmodule

// File: rtl/regwin_coreport.sv
module regwin_coreport
  import regwin_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               hst_valid,
  input  target_e            tgt,
  input  logic [OFF_W-1:0]   off,
  input  logic               hst_write,
  input  logic [1:0]         hst_size,
  input  logic [DATA_W-1:0]  hst_wdata,
  output logic               is_core,
  output logic               core_valid,
  output logic               core_reg_sel,
  output logic               core_fifo_sel,
  output logic               core_write,
  output logic [CORE_AW-1:0] core_addr,
  output logic [1:0]         core_size,
  output logic [DATA_W-1:0]  core_wdata
);

  logic to_reg, to_fifo;

  assign to_reg  = (tgt == TGT_CORE_REG);
  assign to_fifo = (tgt == TGT_CORE_FIFO);
  assign is_core = to_reg | to_fifo;

  assign core_valid    = hst_valid & is_core;
  assign core_reg_sel  = hst_valid & to_reg;
  assign core_fifo_sel = hst_valid & to_fifo;
  assign core_write    = core_valid & hst_write;
  assign core_size     = core_valid ? hst_size  : 2'd0;
  assign core_wdata    = core_valid ? hst_wdata : '0;

  always_comb begin
    if (to_reg)       core_addr = off[CORE_AW-1:0];
    else if (to_fifo) core_addr = fifo_fold(off);
    else              core_addr = '0;
  end

endmodule

// File: rtl/regwin_decoder.sv
module regwin_decoder
  import regwin_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hst_valid,
  output logic               hst_ready,
  input  logic               hst_write,
  input  logic [ADDR_W-1:0]  hst_addr,
  input  logic [1:0]         hst_size,
  input  logic [DATA_W-1:0]  hst_wdata,
  output logic [DATA_W-1:0]  hst_rdata,
  output logic               core_valid,
  input  logic               core_ready,
  output logic               core_reg_sel,
  output logic               core_fifo_sel,
  output logic               core_write,
  output logic [CORE_AW-1:0] core_addr,
  output logic [1:0]         core_size,
  output logic [DATA_W-1:0]  core_wdata,
  input  logic [DATA_W-1:0]  core_rdata,
  output logic               decode_error
);

  logic [OFF_W-1:0]  off;
  logic              unused_hi_bits;
  logic              local_hit;
  logic [DATA_W-1:0] local_rdata;
  target_e           tgt;
  logic              is_core;
  logic              local_wr_evt;
  logic              bad_wr_evt;
  logic              err_q;

  assign off            = hst_addr[OFF_W-1:0];
  assign unused_hi_bits = ^hst_addr[ADDR_W-1:OFF_W];
  assign tgt            = classify(off, hst_size, local_hit);

  // Named events for the checker.
  assign local_wr_evt = hst_valid & hst_write & (tgt == TGT_LOCAL);
  assign bad_wr_evt   = hst_valid & hst_write & (tgt == TGT_NONE);

  regwin_sysbank #(.DATA_W(DATA_W)) i_sysbank (
    .clk   (clk),
    .rst_n (rst_n),
    .off   (off),
    .wr_en (local_wr_evt),
    .wdata (hst_wdata),
    .hit   (local_hit),
    .rdata (local_rdata)
  );

  regwin_coreport #(.DATA_W(DATA_W)) i_coreport (
    .hst_valid     (hst_valid),
    .tgt           (tgt),
    .off           (off),
    .hst_write     (hst_write),
    .hst_size      (hst_size),
    .hst_wdata     (hst_wdata),
    .is_core       (is_core),
    .core_valid    (core_valid),
    .core_reg_sel  (core_reg_sel),
    .core_fifo_sel (core_fifo_sel),
    .core_write    (core_write),
    .core_addr     (core_addr),
    .core_size     (core_size),
    .core_wdata    (core_wdata)
  );

  assign hst_ready = is_core ? core_ready : 1'b1;

  always_comb begin
    if (is_core)               hst_rdata = core_rdata;
    else if (tgt == TGT_LOCAL) hst_rdata = local_rdata;
    else                       hst_rdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          err_q <= 1'b0;
    else if (bad_wr_evt) err_q <= 1'b1;
  end

  assign decode_error = err_q;

endmodule

// File: rtl/regwin_checker.sv
module regwin_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hst_valid,
  input logic              hst_ready,
  input logic              hst_write,
  input logic [ADDR_W-1:0] hst_addr,
  input logic [1:0]        hst_size,
  input logic [DATA_W-1:0] hst_rdata,
  input logic              core_valid,
  input logic              core_ready,
  input logic              core_reg_sel,
  input logic              core_fifo_sel,
  input logic [8:0]        core_addr,
  input logic [1:0]        core_size,
  input logic              decode_error,
  input logic              bad_wr_evt
);

  assert_one_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_reg_sel, core_fifo_sel}));

  assert_reg_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_reg_sel |-> core_addr == hst_addr[8:0]);

  assert_fifo_fold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    core_fifo_sel |-> (core_addr[1:0] == 2'b00 && core_addr >= 9'h020 && core_addr <= 9'h05C));

  assert_ready_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_valid |-> hst_ready == core_ready);

  assert_legal_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
    core_valid |-> core_size != 2'd3);

  assert_narrow_local_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_valid && !hst_write && hst_addr[11] && hst_size != 2'd2) |-> hst_rdata == '0);

  assert_low_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_valid && !hst_write && hst_addr[11:10] == 2'b00) |-> hst_rdata == '0);

  assert_error_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr_evt |=> decode_error);

  assert_error_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    decode_error |=> decode_error);

  assert_local_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_valid && !core_valid) |-> hst_ready);

endmodule

bind regwin_decoder regwin_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .hst_valid     (hst_valid),
  .hst_ready     (hst_ready),
  .hst_write     (hst_write),
  .hst_addr      (hst_addr),
  .hst_size      (hst_size),
  .hst_rdata     (hst_rdata),
  .core_valid    (core_valid),
  .core_ready    (core_ready),
  .core_reg_sel  (core_reg_sel),
  .core_fifo_sel (core_fifo_sel),
  .core_addr     (core_addr),
  .core_size     (core_size),
  .decode_error  (decode_error),
  .bad_wr_evt    (bad_wr_evt)
);

// File: tb/test_regwin_decoder.sv
`timescale 1ns/1ps
module test_regwin_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_valid = 1'b0;
  logic        hst_ready;
  logic        hst_write = 1'b0;
  logic [15:0] hst_addr = '0;
  logic [1:0]  hst_size = '0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        core_valid, core_reg_sel, core_fifo_sel, core_write;
  logic        core_ready = 1'b0;
  logic [8:0]  core_addr;
  logic [1:0]  core_size;
  logic [31:0] core_wdata;
  logic [31:0] core_rdata;
  logic        decode_error;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  // Core responder: read data is a function of address and size.
  assign core_rdata = 32'hC0DE_0000 | {21'd0, core_size, core_addr};

  regwin_decoder i_regwin_decoder (
    .clk(clk), .rst_n(rst_n),
    .hst_valid(hst_valid), .hst_ready(hst_ready), .hst_write(hst_write),
    .hst_addr(hst_addr), .hst_size(hst_size), .hst_wdata(hst_wdata),
    .hst_rdata(hst_rdata),
    .core_valid(core_valid), .core_ready(core_ready),
    .core_reg_sel(core_reg_sel), .core_fifo_sel(core_fifo_sel),
    .core_write(core_write), .core_addr(core_addr), .core_size(core_size),
    .core_wdata(core_wdata), .core_rdata(core_rdata),
    .decode_error(decode_error)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (addr=%h size=%0d wr=%b)",
               tag, act, exp, hst_addr, hst_size, hst_write);
    end
  endtask

  // Reference model state.
  logic [31:0] m_scr, m_trs, n_scr, n_trs;
  logic        m_err, n_err;
  int          cls;          // 0 none, 1 core reg, 2 core fifo, 3 local
  int          off;
  int          exp_caddr;
  logic [31:0] exp_rd;
  string       tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_scr <= 32'h0; m_trs <= 32'h0000_A596; m_err <= 1'b0;
    end else begin
      m_scr <= n_scr; m_trs <= n_trs; m_err <= n_err;
    end
  end

  always @(negedge clk) begin
    n_scr = m_scr; n_trs = m_trs; n_err = m_err;
    if (rst_n) begin
      off = int'(hst_addr) % 4096;
      cls = 0;
      if (hst_size != 2'd3) begin
        if (off >= 'h400 && off < 'h600) cls = 1;
        else if (off >= 'h600 && off < 'h800) cls = 2;
        else if (off >= 'h800 && hst_size == 2'd2 &&
                 (off == 'h9C4 || off == 'h9D8 || off == 'h814 ||
                  off == 'h9F8 || off == 'h9FC)) cls = 3;
      end
      chk("R10", {31'd0, decode_error}, {31'd0, m_err});
      if (hst_valid) begin
        if (cls == 1 || cls == 2) begin
          exp_caddr = (cls == 1) ? (off % 512) : ('h20 + ((off / 8) & 'h3C));
          tag = (hst_addr[15:12] != 0) ? "R1" : ((cls == 1) ? "R2" : "R3");
          chk(tag, {23'd0, core_addr}, exp_caddr[31:0]);
          chk(tag, {30'd0, core_reg_sel, core_fifo_sel}, (cls == 1) ? 32'd2 : 32'd1);
          chk("R4", {31'd0, core_valid}, 32'd1);
          chk("R4", {31'd0, hst_ready}, {31'd0, core_ready});
          chk("R4", {30'd0, core_size}, {30'd0, hst_size});
          chk("R4", {31'd0, core_write}, {31'd0, hst_write});
          if (hst_write) chk("R4", core_wdata, hst_wdata);
          else chk("R4", hst_rdata, 32'hC0DE_0000 | (32'(hst_size) << 9) | exp_caddr[31:0]);
        end else begin
          chk("R11", {31'd0, hst_ready}, 32'd1);
          chk("R11", {31'd0, core_valid}, 32'd0);
          if (cls == 3) begin
            if (off == 'h9C4) begin tag = "R6"; exp_rd = m_scr; end
            else if (off == 'h9D8) begin tag = "R7"; exp_rd = m_trs; end
            else begin
              tag = "R8";
              exp_rd = (off == 'h814) ? 32'h0000_0120 :
                       (off == 'h9F8) ? 32'h5A5A_0011 : 32'h0000_00C3;
            end
            if (!hst_write) chk(tag, hst_rdata, exp_rd);
            else begin
              if (off == 'h9C4) n_scr = hst_wdata;
              if (off == 'h9D8) n_trs = hst_wdata;
            end
          end else begin
            tag = (off >= 'h800 && hst_size != 2'd2) ? "R5" : (hst_write ? "R10" : "R9");
            if (!hst_write) chk(tag, hst_rdata, 32'd0);
            else n_err = 1'b1;
          end
        end
      end
    end
  end

  task automatic access(input logic wr, input logic [15:0] a, input logic [1:0] sz,
                        input logic [31:0] d, input int dly);
    int  cnt;
    logic got;
    cnt = 0;
    hst_valid = 1'b1; hst_write = wr; hst_addr = a; hst_size = sz; hst_wdata = d;
    core_ready = (dly == 0);
    forever begin
      @(negedge clk); got = hst_ready;
      @(posedge clk); #1;
      if (got) break;
      cnt++;
      if (cnt >= dly) core_ready = 1'b1;
    end
    hst_valid = 1'b0; hst_write = 1'b0; core_ready = 1'b0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R10", {31'd0, decode_error}, 32'd0);
    @(posedge clk); #1;
    // Reset values (R6, R7)
    access(1'b0, 16'h09C4, 2'd2, 0, 0);
    access(1'b0, 16'h09D8, 2'd2, 0, 0);
    // Core register port (R2, R4), upper address bits set (R1)
    access(1'b0, 16'h0400, 2'd0, 0, 0);
    access(1'b1, 16'h05FF, 2'd0, 32'h0000_00AB, 2);
    access(1'b0, 16'h0512, 2'd1, 0, 3);
    access(1'b1, 16'h0480, 2'd2, 32'hDEAD_BEEF, 1);
    access(1'b0, 16'hF45C, 2'd2, 0, 0);
    access(1'b1, 16'h3533, 2'd1, 32'h1234_5678, 0);
    // FIFO folding (R3)
    access(1'b0, 16'h0600, 2'd2, 0, 0);
    access(1'b0, 16'h061F, 2'd0, 0, 1);
    access(1'b1, 16'h0620, 2'd2, 32'h0BAD_F00D, 2);
    access(1'b0, 16'h06E3, 2'd1, 0, 0);
    access(1'b0, 16'h07FF, 2'd0, 0, 0);
    access(1'b0, 16'hA7E0, 2'd2, 0, 0);
    // Local registers (R6, R7, R8, R11)
    access(1'b1, 16'h09C4, 2'd2, 32'hCAFE_1234, 0);
    access(1'b0, 16'h09C4, 2'd2, 0, 0);
    access(1'b1, 16'h09D8, 2'd2, 32'h0000_5A69, 0);
    access(1'b0, 16'h09D8, 2'd2, 0, 0);
    access(1'b0, 16'h0814, 2'd2, 0, 0);
    access(1'b1, 16'h0814, 2'd2, 32'hFFFF_FFFF, 0);
    access(1'b0, 16'h0814, 2'd2, 0, 0);
    access(1'b0, 16'h09F8, 2'd2, 0, 0);
    access(1'b0, 16'h79FC, 2'd2, 0, 0);
    // Narrow local accesses are unmapped (R5)
    access(1'b0, 16'h09C4, 2'd1, 0, 0);
    access(1'b1, 16'h09C4, 2'd0, 32'h0000_0077, 0);
    access(1'b0, 16'h09C4, 2'd2, 0, 0);
    // Fresh reset, then unmapped reads and writes (R9, R10)
    do_reset();
    access(1'b0, 16'h09C4, 2'd2, 0, 0);
    access(1'b0, 16'h0100, 2'd2, 0, 0);
    access(1'b0, 16'h0A00, 2'd2, 0, 0);
    access(1'b0, 16'h0450, 2'd3, 0, 0);
    access(1'b1, 16'h0100, 2'd2, 32'h1111_1111, 0);
    access(1'b1, 16'h05A0, 2'd3, 32'h2222_2222, 0);
    access(1'b0, 16'h0444, 2'd2, 0, 1);
    repeat (4) @(posedge clk);
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule